// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits on the south-side configuration window of a host bridge. Each CPU access to that window gives three things: a 16-bit window offset, a 32-bit mapping register and the current bus number. The block turns them into a standard type-0 configuration address. The low half of the mapping register supplies the upper 16 bits of a 32-bit intermediate address, and the window offset supplies the lower 16. Bits [31:11] of that intermediate word form a one-hot device select. The device number is the position of its lowest set bit, measured from intermediate bit 11. The function and register fields are copied across unchanged. The access size and direction also travel with the request, so that a disabled window can return the right all-ones read pattern.

Requests enter on a valid/ready stream and leave on one. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field holds still. With the default `REG_OUT = 1`, one register stage sits between the two streams and `in_ready = !out_valid || out_ready`. With `REG_OUT = 0` the translation is purely combinational and the ready and valid signals pass straight through.

Every result falls into exactly one of three outcomes: translated (`out_ok`), missing device select (`out_err`), or window disabled (`out_blocked`).

Top module: `cfgx_xlate`

## Requirements
- R1: A translated result has these fields: bit 31 = 1 (enable), bits [30:24] = 0, bits [23:16] = bus number, bits [15:11] = device, bits [10:8] = function, bits [7:2] = register, bits [1:0] = 0.
- R2: The device number is the index k of the lowest set bit among intermediate bits [31:11]. Intermediate bit 11+k is `in_offset[11+k]` for k < 5 and `in_map[k-5]` for k ≥ 5. If several bits are set, the lowest one wins.
- R3: The function is `in_offset[10:8]` and the register is `in_offset[7:2]`. `in_offset[1:0]` has no effect on the address.
- R4: When `in_map[16]` is 1, the result has out_blocked=1, out_ok=0, out_err=0 and out_addr=0, whatever the other inputs are.
- R5: out_fill is nonzero only for a blocked read (`in_write`=0). Its value depends on `in_size`: 0 gives 0x000000FF, 1 gives 0x0000FFFF, 2 or 3 gives 0xFFFFFFFF. Blocked writes and unblocked results give out_fill=0.
- R6: When `in_map[16]` is 0 and intermediate bits [31:11] are all zero, the result has out_err=1, out_ok=0 and out_addr=0.
- R7: Every result has exactly one of out_ok, out_err and out_blocked set.
- R8: `in_map[31:17]` has no effect on any result.
- R9: With REG_OUT=1, a result appears on out_valid at the clock edge that accepts its request. in_ready = !out_valid || out_ready. While out_valid is high and out_ready is low, all output fields stay stable.
- R10: While rst_n is low, out_valid is 0. The first result after reset is the one for the first request accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_offset | input | 16 | Low 16 bits of the window offset |
| in_map | input | 32 | Mapping register (bits [15:0] upper address, bit 16 disable) |
| in_bus | input | 8 | Current bus number |
| in_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| in_write | input | 1 | 1 for write, 0 for read |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Formatted configuration address |
| out_ok | output | 1 | Translation succeeded |
| out_err | output | 1 | Device select field was all zero |
| out_blocked | output | 1 | Window disabled by the mapping register |
| out_fill | output | 32 | All-ones read data for a blocked read |

## Verification
The checker looks at every result as it appears. It confirms that exactly one outcome flag is set, that translated addresses carry the enable bit and zero padding, that non-translated addresses are zero, that only blocked reads carry a fill pattern, and that the output holds steady and ready stays low under back-pressure. The correct device number for each one-hot and multi-hot select pattern cannot be checked this way. Neither can function and register pass-through, the independence from the ignored mapping bits, or the per-size fill values. The scoreboard scenarios cover these by sweeping every select bit, every function and several register offsets against an independent model, with and without random back-pressure.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int ADDR_W    = 32;
  localparam int OFS_W     = 16;
  localparam int MAP_LO_W  = ADDR_W - OFS_W;
  localparam int SEL_LSB   = 11;
  localparam int SEL_W     = ADDR_W - SEL_LSB;
  localparam int DEV_W     = 5;
  localparam int FUN_W     = 3;
  localparam int FUN_LSB   = 8;
  localparam int REGN_W    = 6;
  localparam int REGN_LSB  = 2;
  localparam int BUS_W     = 8;
  localparam int BUS_LSB   = 16;
  localparam int BLOCK_BIT = 16;
  localparam int EN_BIT    = 31;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic              ok;
    logic              err;
    logic              blocked;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] fill;
  } xl_result_t;

  localparam int RES_W = $bits(xl_result_t);

  function automatic logic [ADDR_W-1:0] ones_for(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: ones_for = 32'h0000_00FF;
      SZ_HALF: ones_for = 32'h0000_FFFF;
      default: ones_for = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgx_split.sv
module cfgx_split
  import cfgx_pkg::*;
(
  input  logic [OFS_W-1:0]  offset,
  input  logic [ADDR_W-1:0] map,
  output logic [SEL_W-1:0]  sel,
  output logic [FUN_W-1:0]  fun,
  output logic [REGN_W-1:0] regn,
  output logic              blocked
);
  logic [ADDR_W-1:0] inter;
  logic unused_bits;

  assign inter   = {map[MAP_LO_W-1:0], offset};
  assign sel     = inter[ADDR_W-1:SEL_LSB];
  assign fun     = inter[FUN_LSB+FUN_W-1:FUN_LSB];
  assign regn    = inter[REGN_LSB+REGN_W-1:REGN_LSB];
  assign blocked = map[BLOCK_BIT];
  assign unused_bits = ^{map[ADDR_W-1:BLOCK_BIT+1], inter[REGN_LSB-1:0]};
endmodule

// File: rtl/cfgx_lowbit.sv
module cfgx_lowbit #(
  parameter int W     = 21,
  parameter int OUT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [OUT_W-1:0] idx,
  output logic             any
);
  logic [W-1:0] below;
  logic [W-1:0] first;

  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < W; g++) begin : g_chain
      assign below[g] = below[g-1] | vec[g-1];
    end
    for (g = 0; g < W; g++) begin : g_first
      assign first[g] = vec[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = idx | i[OUT_W-1:0];
    end
  end

  assign any = |vec;
endmodule

// File: rtl/cfgx_stage.sv
module cfgx_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      logic         take;

      assign s_ready = !vld_q || m_ready;
      assign take    = s_valid && s_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (s_ready) begin
          vld_q <= s_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (take) dat_q <= s_data;
      end

      assign m_valid = vld_q;
      assign m_data  = dat_q;
    end else begin : g_comb
      assign s_ready = m_ready;
      assign m_valid = s_valid;
      assign m_data  = s_data;
    end
  endgenerate
endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate
  import cfgx_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OFS_W-1:0]  in_offset,
  input  logic [ADDR_W-1:0] in_map,
  input  logic [BUS_W-1:0]  in_bus,
  input  logic [1:0]        in_size,
  input  logic              in_write,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ok,
  output logic              out_err,
  output logic              out_blocked,
  output logic [ADDR_W-1:0] out_fill
);
  logic [SEL_W-1:0]  sel;
  logic [FUN_W-1:0]  fun;
  logic [REGN_W-1:0] regn;
  logic              blk;
  logic [DEV_W-1:0]  dev;
  logic              sel_any;
  xl_result_t        res_d;
  xl_result_t        res_q;
  logic [RES_W-1:0]  res_q_bits;

  cfgx_split u_split (
    .offset (in_offset),
    .map    (in_map),
    .sel    (sel),
    .fun    (fun),
    .regn   (regn),
    .blocked(blk)
  );

  cfgx_lowbit #(.W(SEL_W), .OUT_W(DEV_W)) u_low (
    .vec(sel),
    .idx(dev),
    .any(sel_any)
  );

  always_comb begin
    res_d = '0;
    if (blk) begin
      res_d.blocked = 1'b1;
      res_d.fill    = in_write ? '0 : ones_for(in_size);
    end else if (!sel_any) begin
      res_d.err = 1'b1;
    end else begin
      res_d.ok = 1'b1;
      res_d.addr[EN_BIT]                      = 1'b1;
      res_d.addr[BUS_LSB+BUS_W-1:BUS_LSB]     = in_bus;
      res_d.addr[SEL_LSB+DEV_W-1:SEL_LSB]     = dev;
      res_d.addr[FUN_LSB+FUN_W-1:FUN_LSB]     = fun;
      res_d.addr[REGN_LSB+REGN_W-1:REGN_LSB]  = regn;
    end
  end

  cfgx_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (res_d),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (res_q_bits)
  );

  assign res_q       = xl_result_t'(res_q_bits);
  assign out_addr    = res_q.addr;
  assign out_ok      = res_q.ok;
  assign out_err     = res_q.err;
  assign out_blocked = res_q.blocked;
  assign out_fill    = res_q.fill;
endmodule

// File: rtl/cfgx_xlate_chk.sv
module cfgx_xlate_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_addr,
  input logic        out_ok,
  input logic        out_err,
  input logic        out_blocked,
  input logic [31:0] out_fill
);
  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_ok, out_err, out_blocked}) == 1);

  // R1
  addr_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ok) |-> (out_addr[31] && out_addr[30:24] == 7'd0 && out_addr[1:0] == 2'd0));

  // R4 R6
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ok) |-> out_addr == 32'd0);

  // R5
  fill_only_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_blocked) |-> out_fill == 32'd0);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_fill)
                                   && $stable({out_ok, out_err, out_blocked})));

  generate
    if (REG_OUT) begin : g_regchk
      // R9
      stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end
  endgenerate
endmodule

bind cfgx_xlate cfgx_xlate_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_ok     (out_ok),
  .out_err    (out_err),
  .out_blocked(out_blocked),
  .out_fill   (out_fill)
);

// File: tb/cfgx_xlate_test.sv
`timescale 1ns/100ps
module cfgx_xlate_test;
  import cfgx_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_offset = '0;
  logic [31:0] in_map = '0;
  logic [7:0]  in_bus = '0;
  logic [1:0]  in_size = '0;
  logic        in_write = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_ok, out_err, out_blocked;
  logic [31:0] out_fill;

  int checks = 0;
  int fails  = 0;
  bit bp_en  = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  xl_result_t exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cfgx_xlate uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_offset(in_offset), .in_map(in_map), .in_bus(in_bus), .in_size(in_size),
    .in_write(in_write), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_ok(out_ok), .out_err(out_err),
    .out_blocked(out_blocked), .out_fill(out_fill)
  );

  function automatic xl_result_t model(input logic [15:0] ofs, input logic [31:0] map,
                                       input logic [7:0] bus, input logic [1:0] sz,
                                       input logic wr);
    xl_result_t r;
    logic [31:0] iv;
    int dev;
    r = '0;
    iv = {map[15:0], ofs};
    dev = -1;
    for (int k = 20; k >= 0; k--) if (iv[11+k]) dev = k;
    if (map[16]) begin
      r.blocked = 1'b1;
      if (!wr) r.fill = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    end else if (dev < 0) begin
      r.err = 1'b1;
    end else begin
      r.ok = 1'b1;
      r.addr = 32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11)
             | (32'(ofs[10:8]) << 8) | (32'(ofs[7:2]) << 2);
    end
    return r;
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // driver: caller is at a falling edge
  task automatic send(input logic [15:0] ofs, input logic [31:0] map, input logic [7:0] bus,
                      input logic [1:0] sz, input logic wr, input string tag);
    in_offset = ofs; in_map = map; in_bus = bus; in_size = sz; in_write = wr;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(ofs, map, bus, sz, wr));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    xl_result_t held;
    bit         was_stall;
    xl_result_t got;
    was_stall = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #2;
      got = '{ok:out_ok, err:out_err, blocked:out_blocked, addr:out_addr, fill:out_fill};
      if (rst_n && was_stall)
        check(out_valid && got == held, "R9", "hold under stall", got, held);
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected result", got, 0);
        end else begin
          xl_result_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, "result", got, e);
        end
      end
      was_stall = rst_n && out_valid && !out_ready;
      held = got;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #2;
    // R10
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after reset",
          {out_valid, in_ready}, 2'b01);
    @(negedge clk);

    // R9 latency: result visible at the edge that accepts it
    send(16'h0800 | 16'h0104, 32'h0, 8'h3C, 2'd2, 1'b0, "R1");
    #2;
    check(out_valid == 1'b1, "R9", "one-cycle latency", out_valid, 1);
    @(negedge clk);

    // R1 R2 R3 R8 sweep: every select bit, every function, several registers
    for (int k = 0; k < 21; k++) begin
      for (int f = 0; f < 8; f++) begin
        for (int r = 0; r < 3; r++) begin
          logic [31:0] iv;
          logic [5:0]  rg;
          logic [31:0] map;
          rg = (r == 0) ? 6'd0 : (r == 1) ? 6'd17 : 6'd63;
          iv = (32'd1 << (11 + k)) | (32'(f) << 8) | (32'(rg) << 2) | 32'(r);
          map = {{15{r[0]}} ^ 15'h2A5C, 1'b0, iv[31:16]};
          send(iv[15:0], map, 8'(k * 7 + f), 2'(r), 1'(f & 1), "R2");
        end
      end
    end

    // R2 multi-hot: lowest wins
    send(16'h3000 | 16'h0210, 32'h0000_0F00, 8'h01, 2'd2, 1'b0, "R2");
    send(16'h0000, 32'h0000_8041, 8'hFE, 2'd2, 1'b1, "R2");
    send(16'hF800, 32'h0000_FFFF, 8'h80, 2'd2, 1'b0, "R2");

    // R3 low offset bits ignored
    send(16'h1007, 32'h0, 8'h05, 2'd0, 1'b0, "R3");
    send(16'h1004, 32'h0, 8'h05, 2'd0, 1'b0, "R3");

    // R4 R5 blocked window
    for (int s = 0; s < 4; s++) send(16'h1234, 32'h0001_0040, 8'h11, 2'(s), 1'b0, "R5");
    send(16'h1234, 32'h0001_0040, 8'h11, 2'd2, 1'b1, "R4");
    send(16'h0000, 32'hFFFF_0000, 8'h11, 2'd0, 1'b0, "R4");

    // R6 missing select
    send(16'h07FC, 32'h0000_0000, 8'h22, 2'd2, 1'b0, "R6");
    send(16'h0000, 32'hFFFE_0000, 8'h22, 2'd1, 1'b1, "R6");

    // R7 R9 mixed traffic under random back-pressure
    bp_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] m;
      m = {lfsr, lfsr ^ 16'h5A5A};
      if (n % 5 == 0) m[16] = 1'b1; else m[16] = 1'b0;
      if (n % 7 == 0) m[15:0] = 16'h0;
      send((n % 7 == 0) ? {5'd0, 11'(n * 13)} : 16'(n * 977 + 3), m, 8'(n), 2'(n),
           1'(n >> 2), "R7");
    end
    bp_en = 1'b0;

    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R9", "all results delivered", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule